// File: doc/BRIEF.md
# 66-Bit Block Framer with Header Side Channel

The framer accepts one 64-bit payload word per valid/ready handshake and emits one 66-bit line block. The payload passes through a self-synchronous scrambler with polynomial x^58 + x^39 + 1. The scrambler works bit-serially, least significant bit first, but all 64 steps are computed in a single clock. A 2-bit header, which is never scrambled, is placed in front of the scrambled payload. The header is always a complementary pair, so it is DC balanced on its own.

In side-channel mode the header carries one user bit per block, coded 1B/2B: one header bit is the user bit and the other is its inverse. In standard mode the same pair marks the block as data or control. The mode is chosen per block and is sampled with the payload.

The scrambler state is seeded with all ones at reset. It advances only when a word is accepted, so a stalled output stage leaves both the pending block and the scrambler untouched.

Top module: `blk66_framer`

## Requirements
- R1: `out_blk[1:0]` is the header, with `out_blk[0]` the first header bit. `out_blk[65:2]` is the scrambled payload, with payload bit i at `out_blk[i+2]`.
- R2: Scrambled bit i is the payload bit XOR the scrambled-stream bits 39 and 58 positions earlier. The bits are processed from bit 0 upward, and the stream continues from one block to the next.
- R3: While `out_valid` is high, `out_blk[0]` and `out_blk[1]` always differ. The header is never scrambled.
- R4: With `mode_std` = 0 (side-channel mode), `out_blk[0]` equals the accepted `in_side` and `out_blk[1]` equals its inverse.
- R5: With `mode_std` = 1 (standard mode), a data block (`in_ctrl` = 0) gets `out_blk[0]`=0 and `out_blk[1]`=1. A control block (`in_ctrl` = 1) gets `out_blk[0]`=1 and `out_blk[1]`=0.
- R6: After reset, `out_valid` is 0 and the scrambler state is all ones. The first accepted block is therefore scrambled from an all-ones history.
- R7: A word accepted on a rising edge (`in_valid` and `in_ready` both high) appears on `out_blk` with `out_valid` high directly after that same edge.
- R8: While `out_valid` is high and `out_ready` is low, `out_blk` and `out_valid` hold. The scrambler state does not advance.
- R9: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R10: A descrambler starting from any state recovers the payload exactly once it has seen 58 scrambled bits. No seed exchange is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_std | input | 1 | Header mode for this word: 0 side channel, 1 data/control |
| in_valid | input | 1 | Payload word offered |
| in_ready | output | 1 | Framer can take a word this cycle |
| in_data | input | 64 | Payload word |
| in_side | input | 1 | Side-channel bit for this word |
| in_ctrl | input | 1 | Control-block flag for this word (standard mode) |
| out_valid | output | 1 | Block on `out_blk` is valid |
| out_ready | input | 1 | Downstream takes the block |
| out_blk | output | 66 | Header in bits 1:0, scrambled payload in bits 65:2 |

## Verification
Every block is due one edge after its handshake. Inputs are driven on the falling edge and the output is compared on the next falling edge, half a period after the accepting edge. `in_ready` is combinational from `out_valid` and `out_ready`, so it is read in the same low phase in which `out_ready` changes. During a stall, the held block and `in_ready` are read on every falling edge of the stall. The block released afterwards must match a scrambler model that advanced only once per accepted word.

// File: rtl/blk66_pkg.sv
package blk66_pkg;

    localparam int PAY_W   = 64;
    localparam int HDR_W   = 2;
    localparam int BLK_W   = PAY_W + HDR_W;
    localparam int SCR_W   = 58;
    localparam int SCR_TAP = 39;

    typedef enum logic {
        HDR_SIDE = 1'b0,
        HDR_STD  = 1'b1
    } hdr_mode_e;

    typedef struct packed {
        logic [PAY_W-1:0] pay;
        logic [HDR_W-1:0] hdr;
    } blk_t;

    typedef struct packed {
        logic [SCR_W-1:0] state;
        logic [PAY_W-1:0] data;
    } scr_res_t;

    // One serial scrambler step per payload bit, bit 0 first, unrolled.
    function automatic scr_res_t scr_step(input logic [SCR_W-1:0] st_in,
                                          input logic [PAY_W-1:0] d_in);
        scr_res_t         r;
        logic [SCR_W-1:0] st;
        logic             b;
        st = st_in;
        r.data = '0;
        for (int i = 0; i < PAY_W; i++) begin
            b = d_in[i] ^ st[SCR_TAP-1] ^ st[SCR_W-1];
            r.data[i] = b;
            st = {st[SCR_W-2:0], b};
        end
        r.state = st;
        return r;
    endfunction

endpackage

// File: rtl/blk66_scrambler.sv
module blk66_scrambler
    import blk66_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic [PAY_W-1:0] din,
    output logic [PAY_W-1:0] dout
);
    logic [SCR_W-1:0] state_q;
    scr_res_t         res;

    always_comb res = scr_step(state_q, din);

    assign dout = res.data;

    always_ff @(posedge clk) begin
        if (rst)      state_q <= '1;
        else if (adv) state_q <= res.state;
    end

    AST_SCR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(state_q)); // R8

    AST_SCR_SEED: assert property (@(posedge clk)
        rst |=> (state_q == '1)); // R6
endmodule

// File: rtl/blk66_hdr_enc.sv
module blk66_hdr_enc
    import blk66_pkg::*;
(
    input  hdr_mode_e        mode,
    input  logic             side,
    input  logic             ctrl,
    output logic [HDR_W-1:0] hdr
);
    logic first_bit;

    always_comb begin
        unique case (mode)
            HDR_STD:  first_bit = ctrl;
            default:  first_bit = side;
        endcase
        hdr = {~first_bit, first_bit};
    end
endmodule

// File: rtl/blk66_out_stage.sv
module blk66_out_stage
    import blk66_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  blk_t din,
    input  logic take,
    output logic valid,
    output blk_t dout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            dout  <= '0;
        end else if (load) begin
            valid <= 1'b1;
            dout  <= din;
        end else if (take) begin
            valid <= 1'b0;
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (valid && !take) |=> (valid && $stable(dout))); // R8
endmodule

// File: rtl/blk66_framer.sv
module blk66_framer
    import blk66_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_std,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PAY_W-1:0]  in_data,
    input  logic              in_side,
    input  logic              in_ctrl,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BLK_W-1:0]  out_blk
);
    logic             accept;
    logic [PAY_W-1:0] scr_data;
    logic [HDR_W-1:0] hdr;
    hdr_mode_e        mode;
    blk_t             nxt_blk;
    blk_t             cur_blk;

    assign in_ready = !out_valid || out_ready;
    assign accept   = in_valid && in_ready;
    assign mode     = hdr_mode_e'(mode_std);

    blk66_scrambler u_scr (
        .clk  (clk),
        .rst  (rst),
        .adv  (accept),
        .din  (in_data),
        .dout (scr_data)
    );

    blk66_hdr_enc u_hdr (
        .mode (mode),
        .side (in_side),
        .ctrl (in_ctrl),
        .hdr  (hdr)
    );

    always_comb begin
        nxt_blk.hdr = hdr;
        nxt_blk.pay = scr_data;
    end

    blk66_out_stage u_out (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .din   (nxt_blk),
        .take  (out_ready),
        .valid (out_valid),
        .dout  (cur_blk)
    );

    assign out_blk = cur_blk;

    AST_HDR_BALANCED: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_blk[0] != out_blk[1])); // R3

    AST_SIDE_MAP: assert property (@(posedge clk) disable iff (rst)
        (accept && !mode_std) |=> (out_valid && out_blk[0] == $past(in_side))); // R4

    AST_STD_MAP: assert property (@(posedge clk) disable iff (rst)
        (accept && mode_std) |=> (out_blk[1:0] == ($past(in_ctrl) ? 2'b01 : 2'b10))); // R5

    AST_READY_FREE: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready); // R9

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> !out_valid); // R6
endmodule

// File: tb/tb_blk66_framer.sv
module tb_blk66_framer;

    logic        clk = 1'b0;
    logic        rst;
    logic        mode_std;
    logic        in_valid;
    logic        in_ready;
    logic [63:0] in_data;
    logic        in_side;
    logic        in_ctrl;
    logic        out_valid;
    logic        out_ready;
    logic [65:0] out_blk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [57:0] m_st;   // bench scrambler model state
    logic [57:0] d_st;   // bench descrambler state

    always #10 clk = ~clk;   // 50 MHz

    blk66_framer dut (
        .clk(clk), .rst(rst), .mode_std(mode_std),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_side(in_side), .in_ctrl(in_ctrl),
        .out_valid(out_valid), .out_ready(out_ready), .out_blk(out_blk)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [65:0] act, input logic [65:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model_scr(input logic [63:0] d);
        logic [63:0] o;
        for (int i = 0; i < 64; i++) begin
            o[i] = d[i] ^ m_st[38] ^ m_st[57];
            m_st = {m_st[56:0], o[i]};
        end
        return o;
    endfunction

    function automatic logic [63:0] model_descr(input logic [63:0] r);
        logic [63:0] o;
        for (int i = 0; i < 64; i++) begin
            o[i] = r[i] ^ d_st[38] ^ d_st[57];
            d_st = {d_st[56:0], r[i]};
        end
        return o;
    endfunction

    // Offer one word, let it be accepted, check the block after the edge.
    task automatic send(input logic [63:0] d, input logic m, input logic s,
                        input logic c, input string req);
        logic [63:0] exp_pay;
        logic [1:0]  exp_hdr;
        @(negedge clk);
        in_valid = 1'b1; in_data = d; mode_std = m; in_side = s; in_ctrl = c;
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        exp_pay = model_scr(d);
        exp_hdr = m ? {~c, c} : {~s, s};
        chk(out_valid === 1'b1, "R7 out_valid", {65'd0, out_valid}, 66'd1);
        chk(out_blk === {exp_pay, exp_hdr}, req, out_blk, {exp_pay, exp_hdr});
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b0; in_data = '0; mode_std = 1'b0;
        in_side = 1'b0; in_ctrl = 1'b0; out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_st = '1;
        chk(out_valid === 1'b0, "R6 idle after reset", {65'd0, out_valid}, 66'd0);
        chk(in_ready === 1'b1, "R9 ready while empty", {65'd0, in_ready}, 66'd1);
        send(64'd0, 1'b0, 1'b0, 1'b0, "R6 first block from all-ones seed");
    endtask

    task automatic t_side;
        send(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1, 1'b0, "R4 side=1 R1 layout");
        send(64'h0123_4567_89AB_CDEF, 1'b0, 1'b0, 1'b1, "R4 side=0 ctrl ignored");
        send(64'hA5A5_5A5A_0F0F_F0F0, 1'b0, 1'b1, 1'b1, "R2 stream continues");
        chk(out_blk[0] !== out_blk[1], "R3 header balanced", out_blk, out_blk ^ 66'd3);
    endtask

    task automatic t_std;
        send(64'hDEAD_BEEF_CAFE_F00D, 1'b1, 1'b1, 1'b0, "R5 data header, side ignored");
        send(64'h1E00_0000_0000_0000, 1'b1, 1'b0, 1'b1, "R5 control header");
    endtask

    task automatic t_stall;
        logic [65:0] held;
        logic [63:0] exp_pay;
        @(negedge clk);
        out_ready = 1'b1; in_valid = 1'b0;
        @(negedge clk);   // stage drained
        in_valid = 1'b1; in_data = 64'h1111_2222_3333_4444; mode_std = 1'b0; in_side = 1'b1;
        out_ready = 1'b0;
        @(negedge clk);
        exp_pay = model_scr(64'h1111_2222_3333_4444);
        held = out_blk;
        chk(held === {exp_pay, 2'b01}, "R8 block before stall", held, {exp_pay, 2'b01});
        in_data = 64'h5555_6666_7777_8888; in_side = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk(in_ready === 1'b0, "R9 ready low in stall", {65'd0, in_ready}, 66'd0);
            @(negedge clk);
            chk(out_blk === held && out_valid === 1'b1, "R8 hold", out_blk, held);
        end
        out_ready = 1'b1;
        #1;
        chk(in_ready === 1'b1, "R9 ready with out_ready", {65'd0, in_ready}, 66'd1);
        @(negedge clk);
        in_valid = 1'b0;
        exp_pay = model_scr(64'h5555_6666_7777_8888);
        chk(out_blk === {exp_pay, 2'b10}, "R8 state held through stall", out_blk, {exp_pay, 2'b10});
        @(negedge clk);
        chk(out_valid === 1'b0, "R7 drained", {65'd0, out_valid}, 66'd0);
    endtask

    task automatic t_descramble;
        logic [63:0] rec;
        logic [63:0] pat;
        d_st = 58'h2AB_CDEF_0123_4567;   // arbitrary, unrelated start
        for (int k = 0; k < 4; k++) begin
            pat = {32'h9E37_79B9 * (k + 1), 32'h7F4A_7C15 ^ k};
            send(pat, 1'b0, k[0], 1'b0, "R2 block");
            rec = model_descr(out_blk[65:2]);
            if (k > 0)
                chk(rec === pat, "R10 self-sync recovery", {2'b0, rec}, {2'b0, pat});
        end
    endtask

    initial begin
        t_reset();
        t_side();
        t_std();
        t_stall();
        t_descramble();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule